// File: doc/BRIEF.md
# Miss-bias pattern value predictor

This block is a small, fully associative side buffer for load value prediction. A baseline predictor, external to the block, flags load addresses that it keeps mispredicting. Each flagged address is promoted into this buffer. From then on the buffer watches the values those loads commit and recognises three recurring shapes: a constant stride, an alternation of two values, and values that each arrive twice in a row. It then offers its own prediction at fetch time, together with a flag that says whether the prediction has earned trust.

There are three inputs and one output interface. The promotion input inserts an address. The fetch lookup is combinational: it returns hit, "a prediction exists", the predicted value and the trusted flag in the same cycle. The commit input carries the address, the actual value and whether the prediction was right. When the buffer is full, a promotion replaces the least recently used entry. A mux outside the block picks between this prediction and the baseline one.

Top module: `mbp_top`

## Requirements
- R1: After reset no address is present. Every lookup returns hit 0, predict 0, value 0 and trusted 0, and all four outputs are 0 whenever the lookup valid input is low.
- R2: A promotion of an absent address takes effect at the next clock edge. It fills the lowest-numbered empty entry. The new entry starts with an all-zero history, no pattern and a confidence counter of 1. A lookup of it then returns hit 1, predict 0 and trusted 0.
- R3: A promotion of an address that is already present changes nothing, and each address is held at most once.
- R4: When no entry is empty, a promotion replaces the least recently used entry. Each cycle exactly one entry is marked most recent, chosen in this order of priority: the entry allocated by a promotion, then the entry hit by a commit, then the entry hit by a lookup.
- R5: A commit whose address matches an entry shifts that entry's history. The new value becomes h0 (newest), and the old h0, h1 and h2 move to h1, h2 and h3. A commit to an absent address has no effect.
- R6: Stride pattern (code 2): after a commit, if h0-h1, h1-h2 and h2-h3 are equal and nonzero (arithmetic modulo the value width), the entry predicts h0 + (h0 - h1). This test is applied first.
- R7: Paired-repeat pattern (code 3), tested second and third. If h0==h1, h2==h3 and h1!=h2, a pair has just completed, and the entry is code 3 with no prediction. Otherwise, if the entry was code 3 with a completed pair, h1==h2 and h0!=h1, the entry stays code 3 and predicts h0.
- R8: Alternation pattern (code 1), tested fourth: if h0==h2 and h1==h3, the entry predicts h1.
- R9: When none of these tests holds, the entry has code 0. It makes no prediction and returns predict 0 and value 0.
- R10: The 2-bit confidence counter moves by one on each matching commit. It counts up when the commit is marked correct and down when it is not, and it stops at 3 and at 0. Trusted is 1 only when a prediction exists and the counter is 2 or more.
- R11: A lookup in the same cycle as a commit to the same address returns the state from before that commit. If a promotion replaces the entry that a commit in the same cycle targets, the promotion wins and the commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prom_valid_i | input | 1 | Promotion request |
| prom_addr_i | input | ADDR_W | Address to promote |
| look_valid_i | input | 1 | Fetch lookup request |
| look_addr_i | input | ADDR_W | Address to look up |
| cmt_valid_i | input | 1 | Commit update |
| cmt_addr_i | input | ADDR_W | Committing load address |
| cmt_value_i | input | VAL_W | Value actually loaded |
| cmt_ok_i | input | 1 | The prediction for this load was correct |
| look_hit_o | output | 1 | Looked-up address is held |
| look_pred_o | output | 1 | The entry offers a prediction |
| look_value_o | output | VAL_W | Predicted value, 0 when none |
| look_trust_o | output | 1 | Prediction exists and confidence is 2 or more |

## Verification
The paired-repeat phase is the hardest state to reach. It only comes about after a history of a,a,b,b has been committed and a fresh value then arrives. The directed stimulus therefore commits 231,231,0,0,233,233,4 to one address and checks that the prediction appears and disappears on alternate commits.

Replacing an entry in the same cycle that a commit targets it needs the exact LRU order to be known. So the stimulus first fills the buffer, refreshes the entries in a chosen order, and then issues the conflicting promotion and commit together. After that, a long random mix of the three interfaces over a small address pool is compared against the behavioural model on every cycle.

// File: rtl/mbp_pkg.sv
package mbp_pkg;

    typedef enum logic [1:0] {
        PAT_NONE   = 2'd0,
        PAT_ITER   = 2'd1,
        PAT_STRIDE = 2'd2,
        PAT_PAIR   = 2'd3
    } pat_e;

    localparam int HIST_DEPTH = 4;
    localparam int CONF_W     = 2;

    typedef logic [CONF_W-1:0] conf_t;

    localparam conf_t CONF_INIT  = conf_t'(1);
    localparam conf_t CONF_TRUST = conf_t'(2);

    typedef struct packed {
        pat_e pat;
        logic pair_done;
    } cls_t;

    function automatic conf_t conf_step(conf_t c, logic ok);
        if (ok)
            return (c == '1) ? c : c + conf_t'(1);
        return (c == '0) ? c : c - conf_t'(1);
    endfunction

endpackage

// File: rtl/mbp_entry.sv
module mbp_entry
    import mbp_pkg::*;
#(
    parameter int AW = 32,
    parameter int VW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc_i,
    input  logic [AW-1:0] alloc_addr_i,
    input  logic          upd_i,
    input  logic [VW-1:0] upd_val_i,
    input  logic          upd_ok_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output logic          pred_on_o,
    output logic [VW-1:0] pred_val_o,
    output logic          trusted_o
);

    logic          valid_q;
    logic [AW-1:0] addr_q;
    logic [VW-1:0] hist_q [HIST_DEPTH];
    cls_t          cls_q;
    conf_t         conf_q;

    logic [VW-1:0] nh [HIST_DEPTH];
    logic [VW-1:0] d1, d2, d3;
    cls_t          cls_d;

    // history as it will look after this commit
    always_comb begin
        nh[0] = upd_val_i;
        for (int i = 1; i < HIST_DEPTH; i++)
            nh[i] = hist_q[i-1];
    end

    always_comb begin
        d1 = nh[0] - nh[1];
        d2 = nh[1] - nh[2];
        d3 = nh[2] - nh[3];
        cls_d.pat       = PAT_NONE;
        cls_d.pair_done = 1'b0;
        if (d1 == d2 && d2 == d3 && d1 != '0) begin
            cls_d.pat = PAT_STRIDE;
        end else if (nh[0] == nh[1] && nh[2] == nh[3] && nh[1] != nh[2]) begin
            cls_d.pat       = PAT_PAIR;
            cls_d.pair_done = 1'b1;
        end else if (cls_q.pat == PAT_PAIR && cls_q.pair_done &&
                     nh[1] == nh[2] && nh[0] != nh[1]) begin
            cls_d.pat = PAT_PAIR;
        end else if (nh[0] == nh[2] && nh[1] == nh[3]) begin
            cls_d.pat = PAT_ITER;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q         <= 1'b0;
            addr_q          <= '0;
            for (int i = 0; i < HIST_DEPTH; i++)
                hist_q[i] <= '0;
            cls_q.pat       <= PAT_NONE;
            cls_q.pair_done <= 1'b0;
            conf_q          <= '0;
        end else if (alloc_i) begin
            valid_q         <= 1'b1;
            addr_q          <= alloc_addr_i;
            for (int i = 0; i < HIST_DEPTH; i++)
                hist_q[i] <= '0;
            cls_q.pat       <= PAT_NONE;
            cls_q.pair_done <= 1'b0;
            conf_q          <= CONF_INIT;
        end else if (upd_i) begin
            for (int i = 0; i < HIST_DEPTH; i++)
                hist_q[i] <= nh[i];
            cls_q  <= cls_d;
            conf_q <= conf_step(conf_q, upd_ok_i);
        end
    end

    always_comb begin
        pred_on_o  = 1'b0;
        pred_val_o = '0;
        case (cls_q.pat)
            PAT_ITER: begin
                pred_on_o  = 1'b1;
                pred_val_o = hist_q[1];
            end
            PAT_STRIDE: begin
                pred_on_o  = 1'b1;
                pred_val_o = hist_q[0] + (hist_q[0] - hist_q[1]);
            end
            PAT_PAIR: begin
                if (!cls_q.pair_done) begin
                    pred_on_o  = 1'b1;
                    pred_val_o = hist_q[0];
                end
            end
            default: ;
        endcase
    end

    assign trusted_o = pred_on_o && (conf_q >= CONF_TRUST);
    assign valid_o   = valid_q;
    assign addr_o    = addr_q;

endmodule

// File: rtl/mbp_lru.sv
module mbp_lru #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_i,
    input  logic [IW-1:0] touch_idx_i,
    output logic [IW-1:0] victim_o
);

    // older_q[r][c] set: entry r was used before entry c
    logic [N-1:0] older_q [N];
    logic [N-1:0] row_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++)
                    older_q[r][c] <= (r < c);
        end else if (touch_i) begin
            for (int r = 0; r < N; r++) begin
                if (touch_idx_i == IW'(r))
                    older_q[r] <= '0;
                else
                    older_q[r][touch_idx_i] <= 1'b1;
            end
        end
    end

    for (genvar r = 0; r < N; r++) begin : g_row
        localparam logic [N-1:0] SELF = N'(1) << r;
        assign row_old[r] = &(older_q[r] | SELF);
    end

    always_comb begin
        victim_o = '0;
        for (int i = N - 1; i >= 0; i--)
            if (row_old[i])
                victim_o = IW'(i);
    end

endmodule

// File: rtl/mbp_top.sv
module mbp_top
    import mbp_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ADDR_W  = 32,
    parameter int VAL_W   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prom_valid_i,
    input  logic [ADDR_W-1:0] prom_addr_i,
    input  logic              look_valid_i,
    input  logic [ADDR_W-1:0] look_addr_i,
    input  logic              cmt_valid_i,
    input  logic [ADDR_W-1:0] cmt_addr_i,
    input  logic [VAL_W-1:0]  cmt_value_i,
    input  logic              cmt_ok_i,
    output logic              look_hit_o,
    output logic              look_pred_o,
    output logic [VAL_W-1:0]  look_value_o,
    output logic              look_trust_o
);

    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] ent_valid, pred_on, trusted;
    logic [ADDR_W-1:0]  ent_addr [ENTRIES];
    logic [VAL_W-1:0]   pred_val [ENTRIES];
    logic [ENTRIES-1:0] lk_match, cm_match, pr_match, alloc_vec, upd_vec;

    logic          free_any, alloc_en, cm_hit, lk_any, touch_en;
    logic [IW-1:0] free_idx, lru_idx, alloc_idx, cm_idx, lk_idx, touch_idx;

    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
        assign lk_match[k]  = look_valid_i && ent_valid[k] && ent_addr[k] == look_addr_i;
        assign cm_match[k]  = cmt_valid_i  && ent_valid[k] && ent_addr[k] == cmt_addr_i;
        assign pr_match[k]  = ent_valid[k] && ent_addr[k] == prom_addr_i;
        assign alloc_vec[k] = alloc_en && alloc_idx == IW'(k);
        assign upd_vec[k]   = cm_match[k] && !alloc_vec[k];

        mbp_entry #(.AW(ADDR_W), .VW(VAL_W)) u_entry (
            .clk          (clk),
            .rst          (rst),
            .alloc_i      (alloc_vec[k]),
            .alloc_addr_i (prom_addr_i),
            .upd_i        (upd_vec[k]),
            .upd_val_i    (cmt_value_i),
            .upd_ok_i     (cmt_ok_i),
            .valid_o      (ent_valid[k]),
            .addr_o       (ent_addr[k]),
            .pred_on_o    (pred_on[k]),
            .pred_val_o   (pred_val[k]),
            .trusted_o    (trusted[k])
        );
    end

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        cm_idx   = '0;
        lk_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_any = 1'b1;
                free_idx = IW'(i);
            end
            if (cm_match[i]) cm_idx = IW'(i);
            if (lk_match[i]) lk_idx = IW'(i);
        end
    end

    assign alloc_en  = prom_valid_i && !(|pr_match);
    assign alloc_idx = free_any ? free_idx : lru_idx;
    assign cm_hit    = |cm_match;
    assign lk_any    = |lk_match;
    assign touch_en  = alloc_en || cm_hit || lk_any;
    assign touch_idx = alloc_en ? alloc_idx : (cm_hit ? cm_idx : lk_idx);

    mbp_lru #(.N(ENTRIES)) u_lru (
        .clk         (clk),
        .rst         (rst),
        .touch_i     (touch_en),
        .touch_idx_i (touch_idx),
        .victim_o    (lru_idx)
    );

    always_comb begin
        look_value_o = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (lk_match[i] && pred_on[i])
                look_value_o = pred_val[i];
    end

    assign look_hit_o   = lk_any;
    assign look_pred_o  = |(lk_match & pred_on);
    assign look_trust_o = |(lk_match & trusted);

endmodule

// File: rtl/mbp_chk.sv
module mbp_chk #(
    parameter int N  = 8,
    parameter int AW = 32,
    parameter int VW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          prom_valid_i,
    input logic [AW-1:0] prom_addr_i,
    input logic          look_valid_i,
    input logic [AW-1:0] look_addr_i,
    input logic          cmt_valid_i,
    input logic          look_hit_o,
    input logic          look_pred_o,
    input logic [VW-1:0] look_value_o,
    input logic          look_trust_o,
    input logic [N-1:0]  lk_match,
    input logic [N-1:0]  pr_match
);

    p_reset_empty_r1: assert property (@(posedge clk) rst |=> !look_hit_o);

    p_single_copy_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    p_promote_lands_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(prom_valid_i) && prom_addr_i == $past(prom_addr_i))
        |-> (|pr_match));

    p_trust_needs_pred_r10: assert property (@(posedge clk) disable iff (rst)
        look_trust_o |-> (look_pred_o && look_hit_o));

    p_silent_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !look_pred_o |-> look_value_o == '0);

    p_steady_without_writes_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(prom_valid_i) && !$past(cmt_valid_i) &&
         $past(look_valid_i) && look_valid_i && look_addr_i == $past(look_addr_i))
        |-> (look_value_o == $past(look_value_o) && look_pred_o == $past(look_pred_o)
             && look_trust_o == $past(look_trust_o) && look_hit_o == $past(look_hit_o)));

endmodule

bind mbp_top mbp_chk #(.N(ENTRIES), .AW(ADDR_W), .VW(VAL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .prom_valid_i (prom_valid_i),
    .prom_addr_i  (prom_addr_i),
    .look_valid_i (look_valid_i),
    .look_addr_i  (look_addr_i),
    .cmt_valid_i  (cmt_valid_i),
    .look_hit_o   (look_hit_o),
    .look_pred_o  (look_pred_o),
    .look_value_o (look_value_o),
    .look_trust_o (look_trust_o),
    .lk_match     (lk_match),
    .pr_match     (pr_match)
);

// File: tb/mbp_top_tb.sv
module mbp_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int VW = 32;

    logic          clk, rst;
    logic          prom_valid, look_valid, cmt_valid, cmt_ok;
    logic [AW-1:0] prom_addr, look_addr, cmt_addr;
    logic [VW-1:0] cmt_value;
    logic          o_hit, o_pred, o_trust;
    logic [VW-1:0] o_value;

    mbp_top #(.ENTRIES(N), .ADDR_W(AW), .VAL_W(VW)) u_dut (
        .clk(clk), .rst(rst),
        .prom_valid_i(prom_valid), .prom_addr_i(prom_addr),
        .look_valid_i(look_valid), .look_addr_i(look_addr),
        .cmt_valid_i(cmt_valid), .cmt_addr_i(cmt_addr),
        .cmt_value_i(cmt_value), .cmt_ok_i(cmt_ok),
        .look_hit_o(o_hit), .look_pred_o(o_pred),
        .look_value_o(o_value), .look_trust_o(o_trust)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference state
    bit            m_v   [N];
    logic [AW-1:0] m_a   [N];
    logic [VW-1:0] m_h   [N][4];
    int            m_pat [N];
    bit            m_done[N];
    int            m_c   [N];
    int            m_st  [N];
    int            stamp;

    int    n_chk, n_fail;
    string cur_req;
    bit    reported;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        end
    endtask

    function automatic int m_find(logic [AW-1:0] a);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_a[i] == a) return i;
        return -1;
    endfunction

    task automatic m_expect(input logic [AW-1:0] a, output bit h, output bit p,
                            output logic [VW-1:0] v, output bit t);
        int e;
        e = m_find(a);
        h = 0; p = 0; v = '0; t = 0;
        if (e >= 0) begin
            h = 1;
            if (m_pat[e] == 1) begin p = 1; v = m_h[e][1]; end
            else if (m_pat[e] == 2) begin p = 1; v = m_h[e][0] + (m_h[e][0] - m_h[e][1]); end
            else if (m_pat[e] == 3 && !m_done[e]) begin p = 1; v = m_h[e][0]; end
            t = p && (m_c[e] >= 2);
        end
    endtask

    task automatic m_reset();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_pat[i] = 0; m_done[i] = 0; m_c[i] = 0; m_st[i] = i;
        end
        stamp = N;
    endtask

    task automatic m_step();
        int ce, le, ae, tc, oldest;
        logic [VW-1:0] g0, g1, g2, g3, e1, e2, e3;
        ce = cmt_valid  ? m_find(cmt_addr)  : -1;
        le = look_valid ? m_find(look_addr) : -1;
        ae = -1;
        if (prom_valid && m_find(prom_addr) < 0) begin
            for (int i = N - 1; i >= 0; i--) if (!m_v[i]) ae = i;
            if (ae < 0) begin
                oldest = 0;
                for (int i = 1; i < N; i++) if (m_st[i] < m_st[oldest]) oldest = i;
                ae = oldest;
            end
        end
        if (ce >= 0 && ce != ae) begin
            g0 = cmt_value; g1 = m_h[ce][0]; g2 = m_h[ce][1]; g3 = m_h[ce][2];
            e1 = g0 - g1; e2 = g1 - g2; e3 = g2 - g3;
            if (e1 == e2 && e2 == e3 && e1 != 0) begin m_pat[ce] = 2; m_done[ce] = 0; end
            else if (g0 == g1 && g2 == g3 && g1 != g2) begin m_pat[ce] = 3; m_done[ce] = 1; end
            else if (m_pat[ce] == 3 && m_done[ce] && g1 == g2 && g0 != g1) begin m_pat[ce] = 3; m_done[ce] = 0; end
            else if (g0 == g2 && g1 == g3) begin m_pat[ce] = 1; m_done[ce] = 0; end
            else begin m_pat[ce] = 0; m_done[ce] = 0; end
            m_h[ce][0] = g0; m_h[ce][1] = g1; m_h[ce][2] = g2; m_h[ce][3] = g3;
            if (cmt_ok) begin if (m_c[ce] < 3) m_c[ce]++; end
            else        begin if (m_c[ce] > 0) m_c[ce]--; end
        end
        if (ae >= 0) begin
            m_v[ae] = 1; m_a[ae] = prom_addr; m_pat[ae] = 0; m_done[ae] = 0; m_c[ae] = 1;
            for (int j = 0; j < 4; j++) m_h[ae][j] = '0;
        end
        tc = (ae >= 0) ? ae : ((ce >= 0) ? ce : le);
        if (tc >= 0) begin m_st[tc] = stamp; stamp++; end
    endtask

    task automatic chk4(input string req, input bit eh, input bit ep,
                        input logic [VW-1:0] ev, input bit et);
        n_chk++;
        if (o_hit !== eh || o_pred !== ep || o_value !== ev || o_trust !== et) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b pred=%0b val=%0d trust=%0b exp hit=%0b pred=%0b val=%0d trust=%0b",
                     req, o_hit, o_pred, o_value, o_trust, eh, ep, ev, et);
        end
    endtask

    task automatic settle();
        bit h, p, t;
        logic [VW-1:0] v;
        #1;
        h = 0; p = 0; t = 0; v = '0;
        if (look_valid) m_expect(look_addr, h, p, v, t);
        chk4(cur_req, h, p, v, t);
    endtask

    task automatic tick_clk();
        m_step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        prom_valid = 0; look_valid = 0; cmt_valid = 0; cmt_ok = 0;
        prom_addr = '0; look_addr = '0; cmt_addr = '0; cmt_value = '0;
    endtask

    task automatic promote(input logic [AW-1:0] a);
        idle(); prom_valid = 1; prom_addr = a; settle(); tick_clk();
    endtask

    task automatic commit(input logic [AW-1:0] a, input logic [VW-1:0] v, input bit ok);
        idle(); cmt_valid = 1; cmt_addr = a; cmt_value = v; cmt_ok = ok; settle(); tick_clk();
    endtask

    task automatic look(input string req, input logic [AW-1:0] a, input bit eh,
                        input bit ep, input logic [VW-1:0] ev, input bit et);
        idle(); look_valid = 1; look_addr = a; settle();
        chk4(req, eh, ep, ev, et);
        tick_clk();
    endtask

    function automatic logic [AW-1:0] ad(int i);
        return AW'(32'h1000 + 16 * i);
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        report();
        $finish;
    end

    initial begin : main
        int vpool [12];
        n_chk = 0; n_fail = 0; reported = 0;
        idle(); m_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        cur_req = "R1";
        look("R1", ad(0), 0, 0, 0, 0);
        idle(); settle(); tick_clk();

        cur_req = "R2";
        promote(ad(0));
        look("R2", ad(0), 1, 0, 0, 0);
        look("R9", ad(0), 1, 0, 0, 0);

        cur_req = "R6";
        commit(ad(0), 10, 1); commit(ad(0), 13, 1);
        commit(ad(0), 16, 1); commit(ad(0), 19, 1);
        look("R6", ad(0), 1, 1, 22, 1);

        cur_req = "R10";
        commit(ad(0), 22, 0); commit(ad(0), 25, 0);
        commit(ad(0), 28, 0); commit(ad(0), 31, 0);
        look("R10", ad(0), 1, 1, 34, 0);
        commit(ad(0), 34, 1); commit(ad(0), 37, 1);
        look("R10", ad(0), 1, 1, 40, 1);

        cur_req = "R8";
        promote(ad(1));
        commit(ad(1), 272, 1); commit(ad(1), 368, 1);
        commit(ad(1), 272, 1); commit(ad(1), 368, 1);
        look("R8", ad(1), 1, 1, 272, 1);

        cur_req = "R7";
        promote(ad(2));
        commit(ad(2), 231, 1); commit(ad(2), 231, 1);
        commit(ad(2), 0, 1);   commit(ad(2), 0, 1);
        look("R7", ad(2), 1, 0, 0, 0);
        commit(ad(2), 233, 1);
        look("R7", ad(2), 1, 1, 233, 1);
        commit(ad(2), 233, 1);
        look("R7", ad(2), 1, 0, 0, 0);
        commit(ad(2), 4, 1);
        look("R7", ad(2), 1, 1, 4, 1);

        cur_req = "R5";
        commit(ad(9), 5, 1);
        look("R5", ad(0), 1, 1, 40, 1);
        look("R5", ad(2), 1, 1, 4, 1);

        cur_req = "R3";
        promote(ad(1));
        look("R3", ad(1), 1, 1, 272, 1);

        cur_req = "R4";
        for (int i = 3; i < 8; i++) promote(ad(i));
        for (int i = 1; i < 8; i++) look("R4", ad(i), 1, (i < 3), (i == 1) ? 272 : ((i == 2) ? 4 : 0), (i < 3));
        look("R4", ad(0), 1, 1, 40, 1);
        promote(ad(8));
        look("R4", ad(1), 0, 0, 0, 0);
        look("R4", ad(8), 1, 0, 0, 0);
        commit(ad(2), 7, 1);
        promote(ad(9));
        look("R4", ad(3), 0, 0, 0, 0);
        look("R4", ad(9), 1, 0, 0, 0);

        cur_req = "R11";
        idle();
        prom_valid = 1; prom_addr = ad(10);
        cmt_valid = 1; cmt_addr = ad(4); cmt_value = 99; cmt_ok = 1;
        settle(); tick_clk();
        look("R11", ad(4), 0, 0, 0, 0);
        look("R11", ad(10), 1, 0, 0, 0);
        idle();
        look_valid = 1; look_addr = ad(0);
        cmt_valid = 1; cmt_addr = ad(0); cmt_value = 40; cmt_ok = 1;
        settle();
        chk4("R11", 1, 1, 40, 1);
        tick_clk();
        look("R11", ad(0), 1, 1, 43, 1);

        cur_req = "R4 random mix";
        for (int i = 0; i < 12; i++) vpool[i] = 100 * i;
        for (int n = 0; n < 4000; n++) begin
            int pa, la, ca;
            idle();
            pa = $urandom_range(0, 11); la = $urandom_range(0, 11); ca = $urandom_range(0, 11);
            prom_valid = ($urandom_range(0, 3) == 0); prom_addr = ad(20 + pa);
            look_valid = ($urandom_range(0, 3) != 0); look_addr = ad(20 + la);
            cmt_valid  = ($urandom_range(0, 1) == 0); cmt_addr  = ad(20 + ca);
            cmt_ok     = $urandom_range(0, 1);
            if ($urandom_range(0, 1) == 0) begin
                vpool[ca] = vpool[ca] + 3;
                cmt_value = VW'(vpool[ca]);
            end else begin
                cmt_value = VW'($urandom_range(0, 2));
            end
            settle();
            tick_clk();
        end

        report();
        $finish;
    end

endmodule